// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block generates the column address for each beat of one SDRAM read or write burst inside an open row of a 256-column bank. A column command is a one-cycle `cmd_start` strobe. On that strobe the block captures the start column, the burst-length code, the ordering bit, the read/write flag and the single-write option. In each following cycle it presents one column on `col_addr` and qualifies it with `col_valid`. On the final beat of a fixed-length burst it raises `col_last`.

A full-page burst walks the whole row modulo 256 and never ends by itself. Any burst can be cut short by `burst_stop`, which the surrounding controller raises for a burst-stop or a precharge command. It can also be replaced by a new column command, which may arrive on any clock. The column stream has no back-pressure: an SDRAM burst advances once per clock once it has started. For that reason the output carries a valid qualifier and no ready input, and a consumer must take the address in the cycle it is presented. The data path and the bank/row logic sit outside this block.

Top module: `sdram_burst_colgen`

## Requirements
- R1: A `cmd_start` sampled high at a rising edge puts the captured start column on `col_addr` with `col_valid` high in the cycle after that edge. Strobes on consecutive cycles are each accepted.
- R2: `len_code` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats, one beat per clock with no gaps. Codes 4, 5 and 6 give a single beat.
- R3: When `order_ilv` is 0, the low log2(length) bits count upward from the start column and wrap inside the aligned block of that length. All higher bits keep the start column's value.
- R4: When `order_ilv` is 1, beat k of a fixed-length burst is the start column XOR k.
- R5: `len_code` 7 selects full page. The column counts upward modulo 256 from the start column whatever the value of `order_ilv`, wraps from 255 to 0, and continues until it is stopped or replaced.
- R6: `col_last` is high exactly on the final beat of a fixed-length burst and never during a full-page burst. `col_valid` falls in the next cycle unless a new command arrives.
- R7: A `cmd_start` during a burst abandons it, and the new start column appears in the next cycle. When `cmd_start` and `burst_stop` are high together, the new burst starts.
- R8: `burst_stop` sampled high during a burst drops `col_valid` from the next cycle. `burst_stop` while idle has no effect.
- R9: With `single_write` = 1, a write command (`cmd_write` = 1) gives a 1-beat burst whatever its length code, and reads keep the programmed length. With `single_write` = 0, writes use the programmed length.
- R10: After reset, and whenever no burst is running, `col_valid` and `col_last` are low and `col_addr` is 0.
- R11: `start_col`, `len_code`, `order_ilv`, `cmd_write` and `single_write` are sampled only in a `cmd_start` cycle. Changes at other times do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Column command strobe (READ or WRITE) |
| cmd_write | input | 1 | 1 = command is a write |
| start_col | input | 8 | Start column of the burst |
| len_code | input | 3 | Burst length: 0..3 = 1/2/4/8 beats, 7 = full page, 4..6 = 1 beat |
| order_ilv | input | 1 | 0 = sequential, 1 = interleaved |
| single_write | input | 1 | 1 = write bursts are one beat long |
| burst_stop | input | 1 | Terminate strobe (burst stop or precharge) |
| col_addr | output | 8 | Current column, 0 when idle |
| col_valid | output | 1 | A burst beat is presented this cycle |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
Every output is a registered result of the previous edge. Beat 0 of a command is due one cycle after the strobe edge, and beat k is due k cycles after that. A stop or a final beat removes `col_valid` one cycle after the edge that samples it. The bench drives inputs one time unit after each rising edge. Its behavioural model advances on that same rising edge, and the outputs are compared with the model at every falling edge, so each expected value is checked in the cycle it becomes due.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int unsigned LEN_W = 3;

  typedef enum logic [LEN_W-1:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd7
  } blen_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_W-1:0] len_code,
  input  logic             is_write,
  input  logic             single_write,
  output logic [COL_W-1:0] wrap_mask,
  output logic             page_mode
);
  logic force_one;
  logic page_sel;
  logic pow_ok;

  assign force_one = is_write & single_write;
  assign page_sel  = (len_code == BLEN_PAGE);
  assign pow_ok    = (len_code <= BLEN_8);
  assign page_mode = page_sel & ~force_one;

  // One mask bit per column bit: set when the bit lies inside the burst window.
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign wrap_mask[b] = ~force_one &
                          (page_sel | (pow_ok & (int'(len_code) > b)));
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             halt,
  input  logic [COL_W-1:0] load_base,
  input  logic [COL_W-1:0] load_mask,
  input  logic             load_page,
  input  logic             load_ilv,
  output logic             run,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask,
  output logic             page,
  output logic             ilv,
  output logic             final_beat
);
  assign final_beat = run & ~page & (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      beat <= '0;
      base <= '0;
      mask <= '0;
      page <= 1'b0;
      ilv  <= 1'b0;
    end else if (load) begin
      run  <= 1'b1;
      beat <= '0;
      base <= load_base;
      mask <= load_mask;
      page <= load_page;
      ilv  <= load_ilv & ~load_page;
    end else if (halt) begin
      run <= 1'b0;
    end else if (run) begin
      if (final_beat) run <= 1'b0;
      else            beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign seq_sum = base + beat;
  assign ilv_col = base ^ beat;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign seq_col[b] = mask[b] ? seq_sum[b] : base[b];
  end

  assign col = ilv ? ilv_col : seq_col;
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len_code,
  input  logic             order_ilv,
  input  logic             single_write,
  input  logic             burst_stop,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             run_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] run_mask;
  logic             run_full;
  logic             ilv_q;
  logic             fin;
  logic [COL_W-1:0] mapped;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code     (len_code),
    .is_write     (cmd_write),
    .single_write (single_write),
    .wrap_mask    (dec_mask),
    .page_mode    (dec_page)
  );

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd_start),
    .halt       (burst_stop),
    .load_base  (start_col),
    .load_mask  (dec_mask),
    .load_page  (dec_page),
    .load_ilv   (order_ilv),
    .run        (run_q),
    .beat       (beat_q),
    .base       (base_q),
    .mask       (run_mask),
    .page       (run_full),
    .ilv        (ilv_q),
    .final_beat (fin)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base (base_q),
    .beat (beat_q),
    .mask (run_mask),
    .ilv  (ilv_q),
    .col  (mapped)
  );

  assign col_valid = run_q;
  assign col_last  = fin;
  assign col_addr  = run_q ? mapped : '0;
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             burst_stop,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last,
  input logic             run_full,
  input logic [COL_W-1:0] run_mask
);
  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> col_valid); // R1

  AST_HIGH_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !cmd_start && !burst_stop) |=>
      ((col_addr & ~run_mask) == ($past(col_addr) & ~run_mask))); // R3

  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && run_full) |-> !col_last); // R5

  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid); // R6

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !cmd_start) |=> !col_valid); // R6

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && !cmd_start) |=> !col_valid); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> (col_addr == '0 && !col_last)); // R10
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .burst_stop (burst_stop),
  .col_addr   (col_addr),
  .col_valid  (col_valid),
  .col_last   (col_last),
  .run_full   (run_full),
  .run_mask   (run_mask)
);

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic       cmd_write = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       order_ilv = 1'b0;
  logic       single_write = 1'b0;
  logic       burst_stop = 1'b0;
  logic [7:0] col_addr;
  logic       col_valid;
  logic       col_last;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag = "R10";

  // behavioural reference state
  int  m_act = 0, m_base = 0, m_beat = 0, m_len = 1, m_full = 0, m_ilv = 0;

  always #4 clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .start_col(start_col), .len_code(len_code), .order_ilv(order_ilv),
    .single_write(single_write), .burst_stop(burst_stop),
    .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_act = 0; m_beat = 0;
    end else if (cmd_start) begin
      m_act  = 1;
      m_base = int'(start_col);
      m_beat = 0;
      m_full = (len_code == 3'd7) ? 1 : 0;
      m_len  = (len_code <= 3'd3) ? (1 << len_code) : (m_full ? 256 : 1);
      if (cmd_write && single_write) begin
        m_len = 1; m_full = 0;
      end
      m_ilv = (order_ilv && !m_full) ? 1 : 0;
    end else if (burst_stop) begin
      m_act = 0;
    end else if (m_act != 0) begin
      if (m_full == 0 && m_beat == m_len - 1) m_act = 0;
      else m_beat = (m_beat + 1) % 256;
    end
  end

  function automatic int exp_addr();
    int off;
    if (m_act == 0) return 0;
    if (m_full != 0) return (m_base + m_beat) % 256;
    if (m_ilv != 0) return m_base ^ m_beat;
    off = m_base % m_len;
    return m_base - off + (off + m_beat) % m_len;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      int ea, ev, el;
      ea = exp_addr();
      ev = m_act;
      el = (m_act != 0 && m_full == 0 && m_beat == m_len - 1) ? 1 : 0;
      checks++;
      if (int'(col_valid) != ev) begin
        failures++;
        $display("FAIL %s col_valid actual=%0d expected=%0d t=%0t", tag, col_valid, ev, $time);
      end
      checks++;
      if (int'(col_addr) != ea) begin
        failures++;
        $display("FAIL %s col_addr actual=%02h expected=%02h t=%0t", tag, col_addr, ea, $time);
      end
      checks++;
      if (int'(col_last) != el) begin
        failures++;
        $display("FAIL %s col_last actual=%0d expected=%0d t=%0t", tag, col_last, el, $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go(input logic [7:0] c, input logic [2:0] l, input logic il,
                    input logic wr, input logic sw);
    start_col = c; len_code = l; order_ilv = il; cmd_write = wr; single_write = sw;
    cmd_start = 1'b1;
    tick(1);
    cmd_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1;
    tick(3);
    // R10: reset state seen at the ports
    checks++;
    if (col_valid !== 1'b0 || col_addr !== 8'h00 || col_last !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset outputs actual=%0d/%02h/%0d expected=0/00/0", col_valid, col_addr, col_last);
    end
    rst_n = 1'b1;
    tick(3);

    tag = "R2"; // all fixed lengths, sequential; reserved codes
    for (int l = 0; l < 4; l++) begin go(8'h35, 3'(l), 1'b0, 1'b0, 1'b0); tick(10); end
    go(8'h35, 3'd5, 1'b0, 1'b0, 1'b0); tick(3);
    go(8'h80, 3'd6, 1'b1, 1'b0, 1'b0); tick(3);

    tag = "R3"; // wrap inside aligned block, high bits fixed
    go(8'hFF, 3'd1, 1'b0, 1'b0, 1'b0); tick(4);
    go(8'h7E, 3'd3, 1'b0, 1'b0, 1'b0); tick(10);

    tag = "R4"; // interleaved
    go(8'h35, 3'd3, 1'b1, 1'b0, 1'b0); tick(10);
    go(8'hC6, 3'd2, 1'b1, 1'b0, 1'b0); tick(6);

    tag = "R5"; // full page, order ignored, wraps 255 -> 0
    go(8'hF0, 3'd7, 1'b1, 1'b0, 1'b0); tick(300);
    burst_stop = 1'b1; tick(1); burst_stop = 1'b0; tick(3);

    tag = "R6"; // last beat then idle
    go(8'h12, 3'd2, 1'b0, 1'b1, 1'b0); tick(8);

    tag = "R7"; // restart mid-burst, start beats stop
    go(8'h40, 3'd3, 1'b0, 1'b0, 1'b0); tick(3);
    go(8'h9B, 3'd2, 1'b1, 1'b0, 1'b0); tick(2);
    burst_stop = 1'b1; go(8'h21, 3'd1, 1'b0, 1'b0, 1'b0); burst_stop = 1'b0; tick(4);

    tag = "R8"; // stop mid-burst and while idle
    go(8'h50, 3'd3, 1'b0, 1'b0, 1'b0); tick(2);
    burst_stop = 1'b1; tick(1); burst_stop = 1'b0; tick(3);
    burst_stop = 1'b1; tick(2); burst_stop = 1'b0; tick(2);

    tag = "R9"; // burst-read / single-write
    go(8'h64, 3'd3, 1'b0, 1'b1, 1'b1); tick(4);
    go(8'h64, 3'd7, 1'b0, 1'b1, 1'b1); tick(4);
    go(8'h64, 3'd3, 1'b0, 1'b0, 1'b1); tick(10);
    go(8'h64, 3'd2, 1'b1, 1'b1, 1'b0); tick(6);

    tag = "R11"; // mode inputs changed with no strobe
    go(8'hA8, 3'd3, 1'b0, 1'b0, 1'b0);
    start_col = 8'h03; len_code = 3'd0; order_ilv = 1'b1; cmd_write = 1'b1; single_write = 1'b1;
    tick(10);

    tag = "R1"; // strobe every cycle
    for (int i = 0; i < 6; i++) begin
      start_col = 8'(i * 37 + 5); len_code = 3'(i % 4); order_ilv = 1'(i % 2);
      cmd_write = 1'b0; single_write = 1'b0; cmd_start = 1'b1;
      tick(1);
    end
    cmd_start = 1'b0;
    tick(10);

    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog actual=%0d cycles expected<=20000", cycles);
    finish_run();
  end
endmodule